// File: doc/BRIEF.md
# Solar Optimizer Mode Sequencer

This block decides which operating state a panel power optimizer is in. After reset it moves into soft-start. It then goes either straight into maximum-power tracking, or into a startup bypass ("startup panel") state, depending on whether the filtered input and output current samples show real load. From tracking it can move to panel mode, where the panel drives the output directly. This happens when the tracker reports a unity conversion ratio, or when the bypass is forced.

In panel mode the block makes two kinds of exit back to tracking:

- a periodic probe, on a fixed tick interval and with a bounded duration, to confirm the operating point;
- an open-ended exit when the output power has drifted from the value captured at entry by more than a programmable fraction.

The forced-bypass request comes from an active-low pin. A select bit can swap that pin for a register control bit.

All timing counts a one-millisecond tick supplied from outside. The block drives a tracking enable for the tracker and a bypass request for the PWM stage. It also exposes its state code.

Top module: `pv_mode_seq`

## Requirements
- R1: While `rst_n` is low the state is RESET (code 0), from any state; in the first clock after release the state becomes SOFT (code 1).
- R2: In SOFT, when `iout > th_out_hi` and `iin > th_in_hi` (both strict), the next state is TRACK, whether or not `soft_done` is set.
- R3: In SOFT without the start condition, the state holds until `soft_done` is 1, then goes to SPM (startup panel, code 2).
- R4: SPM goes to TRACK only when the start condition holds and at least the hold time has passed since entry: `hold_code` 1 gives START_UNIT_MS ticks, 2 gives twice that, 0 and 3 give none. Output power has no effect in SPM.
- R5: In TRACK, the state goes to SPM when `iout < th_out_lo` or `iin < th_in_lo`; currents between the low and high thresholds keep TRACK.
- R6: In TRACK, `unity_ratio` = 1 moves the state to PANEL (code 4).
- R7: PANEL starts a probe into TRACK after CHECK_MS ticks; a probe returns to PANEL after PROBE_MS ticks, or earlier on `unity_ratio`.
- R8: PANEL exits to an unbounded (non-probe) TRACK when `|pout - ref| * 2^SHIFT > ref * pwr_code`; `pwr_code` = 0 disables this exit.
- R9: `ref` is the `pout` value sampled on the clock that enters PANEL, and is resampled on every clock that PANEL is held by force.
- R10: Force is `pm_sel ? pm_reg : !pm_pin_n`. It moves SOFT, SPM and TRACK to PANEL on the next clock, and holds PANEL with no probe or power exit while active.
- R11: With `pm_sel` = 1 the value of `pm_pin_n` has no effect.
- R12: The tick count restarts at every state change and on every clock that PANEL is forced.
- R13: `state` codes are RESET=0, SOFT=1, SPM=2, TRACK=3, PANEL=4; `track_en` is 1 only in TRACK; `pm_req` is 1 in SPM and PANEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| iin | input | SW | Filtered input current sample |
| iout | input | SW | Filtered output current sample |
| pout | input | PW | Output power |
| soft_done | input | 1 | Soft-start ramp finished |
| unity_ratio | input | 1 | Tracker sits at unity conversion ratio |
| pm_pin_n | input | 1 | Active-low forced bypass pin |
| pm_sel | input | 1 | Use register bit instead of pin |
| pm_reg | input | 1 | Register force-bypass bit |
| hold_code | input | 2 | Startup panel hold time select |
| pwr_code | input | CODE_W | Power drift fraction, steps of 2^-SHIFT |
| th_in_hi | input | SW | Input current start threshold |
| th_in_lo | input | SW | Input current stop threshold |
| th_out_hi | input | SW | Output current start threshold |
| th_out_lo | input | SW | Output current stop threshold |
| state | output | 3 | Current state code |
| track_en | output | 1 | Enables the tracking algorithm |
| pm_req | output | 1 | Bypass request to PWM stage |

## Verification
On every cycle, the assertions check several properties:

- reset always exits to soft-start;
- force always lands in and holds panel mode;
- a probe never outlives its tick window;
- startup panel never leaves before its hold count;
- the tick count is zero after each state change and is frozen without a tick;
- the start and stop current bands never overlap for ordered thresholds.

The reference power captured in the power watcher is also tied to the sample taken on entry. Only the directed scenarios show the exact tick count at which a timed exit happens. They also show the strictness of the current and power comparisons at their boundary values, that the resampled reference really governs the later power exit, and that the pin is ignored under register select.

// File: rtl/pv_mode_pkg.sv
`timescale 1ns/1ps
package pv_mode_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_SOFT  = 3'd1,
    ST_SPM   = 3'd2,
    ST_TRACK = 3'd3,
    ST_PANEL = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pv_ms_timer.sv
`timescale 1ns/1ps
// Saturating millisecond counter with synchronous restart.
module pv_ms_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                   cnt_d = '0;
    else if (tick && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R12: count only moves on a tick or a restart
  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(count));
endmodule

// File: rtl/pv_cur_window.sv
`timescale 1ns/1ps
// Hysteretic current window: start needs both currents high, stop needs either low.
module pv_cur_window #(
  parameter int SW = 10
) (
  input  logic [SW-1:0] iin,
  input  logic [SW-1:0] iout,
  input  logic [SW-1:0] th_in_hi,
  input  logic [SW-1:0] th_in_lo,
  input  logic [SW-1:0] th_out_hi,
  input  logic [SW-1:0] th_out_lo,
  output logic          start_ok,
  output logic          stop_req
);
  always_comb begin
    start_ok = (iout > th_out_hi) && (iin > th_in_hi);
    stop_req = (iout < th_out_lo) || (iin < th_in_lo);
  end
endmodule

// File: rtl/pv_power_watch.sv
`timescale 1ns/1ps
// Captures a reference power and flags a relative drift without a divider.
module pv_power_watch #(
  parameter int PW     = 16,
  parameter int SHIFT  = 6,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PW-1:0]     pout,
  input  logic [CODE_W-1:0] code,
  output logic              exceed
);
  localparam int XW = PW + ((SHIFT > CODE_W) ? SHIFT : CODE_W) + 1;

  logic [PW-1:0] ref_q, ref_d;
  logic [PW-1:0] diff;
  logic [XW-1:0] lhs, rhs;

  always_comb begin
    ref_d = load ? pout : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  always_comb begin
    diff   = (pout >= ref_q) ? (pout - ref_q) : (ref_q - pout);
    lhs    = XW'(diff) << SHIFT;
    rhs    = XW'(ref_q) * XW'(code);
    exceed = (code != '0) && (lhs > rhs);
  end

  // R9: reference equals the power seen on the load clock
  p_ref_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ref_q == $past(pout)));
  // R8: a zero code never reports drift
  p_code_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> !exceed);
endmodule

// File: rtl/pv_mode_seq.sv
`timescale 1ns/1ps
module pv_mode_seq
  import pv_mode_pkg::*;
#(
  parameter int SW            = 10,
  parameter int PW            = 16,
  parameter int CODE_W        = 4,
  parameter int SHIFT         = 6,
  parameter int START_UNIT_MS = 60000,
  parameter int CHECK_MS      = 60000,
  parameter int PROBE_MS      = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [SW-1:0]     iin,
  input  logic [SW-1:0]     iout,
  input  logic [PW-1:0]     pout,
  input  logic              soft_done,
  input  logic              unity_ratio,
  input  logic              pm_pin_n,
  input  logic              pm_sel,
  input  logic              pm_reg,
  input  logic [1:0]        hold_code,
  input  logic [CODE_W-1:0] pwr_code,
  input  logic [SW-1:0]     th_in_hi,
  input  logic [SW-1:0]     th_in_lo,
  input  logic [SW-1:0]     th_out_hi,
  input  logic [SW-1:0]     th_out_lo,
  output logic [2:0]        state,
  output logic              track_en,
  output logic              pm_req
);
  localparam int MAX_A = (2 * START_UNIT_MS > CHECK_MS) ? 2 * START_UNIT_MS : CHECK_MS;
  localparam int MAXT  = (MAX_A > PROBE_MS) ? MAX_A : PROBE_MS;
  localparam int CW    = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LIM_UNIT  = CW'(START_UNIT_MS);
  localparam logic [CW-1:0] LIM_UNIT2 = CW'(2 * START_UNIT_MS);
  localparam logic [CW-1:0] LIM_CHECK = CW'(CHECK_MS);
  localparam logic [CW-1:0] LIM_PROBE = CW'(PROBE_MS);

  seq_state_e    st_q, st_d;
  logic          probe_q, probe_d;
  logic          force_pm;
  logic          start_ok, stop_req, pwr_exceed;
  logic          restart, ref_load;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hold_lim;

  pv_cur_window #(.SW(SW)) u_window (
    .iin(iin), .iout(iout),
    .th_in_hi(th_in_hi), .th_in_lo(th_in_lo),
    .th_out_hi(th_out_hi), .th_out_lo(th_out_lo),
    .start_ok(start_ok), .stop_req(stop_req)
  );

  pv_ms_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(ms_tick), .count(cnt)
  );

  pv_power_watch #(.PW(PW), .SHIFT(SHIFT), .CODE_W(CODE_W)) u_power (
    .clk(clk), .rst_n(rst_n), .load(ref_load), .pout(pout),
    .code(pwr_code), .exceed(pwr_exceed)
  );

  always_comb begin
    force_pm = pm_sel ? pm_reg : !pm_pin_n;
    case (hold_code)
      2'd1:    hold_lim = LIM_UNIT;
      2'd2:    hold_lim = LIM_UNIT2;
      default: hold_lim = '0;
    endcase
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    probe_d = 1'b0;
    case (st_q)
      ST_RESET: st_d = ST_SOFT;
      ST_SOFT: begin
        if (force_pm)       st_d = ST_PANEL;
        else if (start_ok)  st_d = ST_TRACK;
        else if (soft_done) st_d = ST_SPM;
      end
      ST_SPM: begin
        if (force_pm)                           st_d = ST_PANEL;
        else if (start_ok && (cnt >= hold_lim)) st_d = ST_TRACK;
      end
      ST_TRACK: begin
        if (force_pm)                             st_d = ST_PANEL;
        else if (stop_req)                        st_d = ST_SPM;
        else if (unity_ratio)                     st_d = ST_PANEL;
        else if (probe_q && (cnt >= LIM_PROBE))   st_d = ST_PANEL;
        probe_d = probe_q && (st_d == ST_TRACK);
      end
      ST_PANEL: begin
        if (!force_pm) begin
          if (pwr_exceed) st_d = ST_TRACK;
          else if (cnt >= LIM_CHECK) begin
            st_d    = ST_TRACK;
            probe_d = 1'b1;
          end
        end
      end
      default: st_d = ST_RESET;
    endcase
  end

  always_comb begin
    restart  = (st_d != st_q) || ((st_q == ST_PANEL) && force_pm);
    ref_load = ((st_d == ST_PANEL) && (st_q != ST_PANEL)) ||
               ((st_q == ST_PANEL) && force_pm);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET;
      probe_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      probe_q <= probe_d;
    end
  end

  always_comb begin
    state    = st_q;
    track_en = (st_q == ST_TRACK);
    pm_req   = (st_q == ST_SPM) || (st_q == ST_PANEL);
  end

  // R1: reset state always hands over to soft-start
  p_reset_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESET) |=> (st_q == ST_SOFT));
  // R10: force drives an operating state into panel mode
  p_force_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_pm && ((st_q == ST_SOFT) || (st_q == ST_SPM) || (st_q == ST_TRACK)))
      |=> (st_q == ST_PANEL));
  // R10: forced panel mode is held
  p_force_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PANEL) && force_pm) |=> (st_q == ST_PANEL));
  // R7: a probe never runs past its tick window
  p_probe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_q && (st_q == ST_TRACK)) |-> (cnt <= LIM_PROBE));
  // R4: startup panel exit only after its hold count
  p_spm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_TRACK) && ($past(st_q) == ST_SPM)) |-> ($past(cnt) >= $past(hold_lim)));
  // R12: every state entry starts from a zero count
  p_entry_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != $past(st_q)) |-> (cnt == '0));
  // R13: tracking and bypass request are never both active
  p_out_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(track_en && pm_req));
  // R5: ordered thresholds give disjoint start and stop bands
  p_band_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((th_out_hi >= th_out_lo) && (th_in_hi >= th_in_lo)) |-> !(start_ok && stop_req));
endmodule

// File: tb/pv_mode_seq_test.sv
`timescale 1ns/1ps
module pv_mode_seq_test;
  localparam int UNIT = 20;
  localparam int CHK  = 30;
  localparam int PRB  = 8;
  localparam int S_RST = 0, S_SOFT = 1, S_SPM = 2, S_TRK = 3, S_PNL = 4;

  logic        clk = 1'b0;
  logic        rst_n, ms_tick, soft_done, unity_ratio, pm_pin_n, pm_sel, pm_reg;
  logic [9:0]  iin, iout, th_in_hi, th_in_lo, th_out_hi, th_out_lo;
  logic [15:0] pout;
  logic [1:0]  hold_code;
  logic [3:0]  pwr_code;
  logic [2:0]  state;
  logic        track_en, pm_req;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pv_mode_seq #(
    .SW(10), .PW(16), .CODE_W(4), .SHIFT(6),
    .START_UNIT_MS(UNIT), .CHECK_MS(CHK), .PROBE_MS(PRB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .iin(iin), .iout(iout), .pout(pout),
    .soft_done(soft_done), .unity_ratio(unity_ratio), .pm_pin_n(pm_pin_n),
    .pm_sel(pm_sel), .pm_reg(pm_reg), .hold_code(hold_code), .pwr_code(pwr_code),
    .th_in_hi(th_in_hi), .th_in_lo(th_in_lo), .th_out_hi(th_out_hi), .th_out_lo(th_out_lo),
    .state(state), .track_en(track_en), .pm_req(pm_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic set_cur(input int a_in, input int a_out);
    iin  = 10'(a_in);
    iout = 10'(a_out);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    cyc(2);
    chk("R1 state in reset", int'(state), S_RST);
    chk("R13 track_en in reset", int'(track_en), 0);
    chk("R13 pm_req in reset", int'(pm_req), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 soft after release", int'(state), S_SOFT);
  endtask

  task automatic t_soft_track();
    soft_done = 1'b0; set_cur(0, 0);
    do_reset();
    cyc(3);
    chk("R3 soft waits for done", int'(state), S_SOFT);
    set_cur(50, 40);
    cyc(2);
    chk("R2 threshold is strict", int'(state), S_SOFT);
    set_cur(50, 41);
    cyc(1);
    chk("R2 soft to track", int'(state), S_TRK);
    chk("R13 track_en in track", int'(track_en), 1);
    chk("R13 pm_req in track", int'(pm_req), 0);
  endtask

  task automatic t_hyst();
    set_cur(30, 30);
    cyc(3);
    chk("R5 mid band keeps track", int'(state), S_TRK);
    set_cur(23, 30);
    cyc(1);
    chk("R5 low current to startup panel", int'(state), S_SPM);
    chk("R13 pm_req in startup panel", int'(pm_req), 1);
  endtask

  task automatic t_spm_hold(input int code, input int lim);
    hold_code = 2'(code); soft_done = 1'b1; set_cur(0, 0);
    do_reset();
    cyc(1);
    chk("R3 soft done to startup panel", int'(state), S_SPM);
    set_cur(50, 50);
    if (lim == 0) begin
      cyc(1);
      chk("R4 zero hold exits at once", int'(state), S_TRK);
    end else begin
      pout = 16'd9000;
      ticks(lim - 1);
      cyc(2);
      chk("R4 hold not elapsed, power ignored", int'(state), S_SPM);
      ticks(1);
      cyc(1);
      chk("R4 hold elapsed to track", int'(state), S_TRK);
    end
    pout = 16'd1000;
  endtask

  task automatic t_unity();
    pout = 16'd1000; unity_ratio = 1'b1;
    cyc(1);
    chk("R6 unity ratio to panel", int'(state), S_PNL);
    chk("R13 pm_req in panel", int'(pm_req), 1);
    unity_ratio = 1'b0;
  endtask

  task automatic t_probe();
    pwr_code = 4'd4;
    ticks(CHK - 1); cyc(2);
    chk("R7 before check interval", int'(state), S_PNL);
    ticks(1); cyc(1);
    chk("R7 probe starts", int'(state), S_TRK);
    ticks(PRB - 1); cyc(2);
    chk("R7 probe still running", int'(state), S_TRK);
    ticks(1); cyc(1);
    chk("R7 probe timeout to panel", int'(state), S_PNL);
    ticks(CHK - 1); cyc(2);
    chk("R12 timer restarted on entry", int'(state), S_PNL);
    ticks(1); cyc(1);
    chk("R7 second probe", int'(state), S_TRK);
    unity_ratio = 1'b1; cyc(1);
    chk("R7 probe ends early on unity", int'(state), S_PNL);
    unity_ratio = 1'b0;
  endtask

  task automatic t_power();
    // ref = 1000, code 4: limit is delta*64 > 4000
    pout = 16'd1062; cyc(3);
    chk("R8 drift 62 below limit", int'(state), S_PNL);
    pout = 16'd1063; cyc(1);
    chk("R8 drift 63 exits", int'(state), S_TRK);
    ticks(PRB + 2); cyc(2);
    chk("R8 power exit is not a probe", int'(state), S_TRK);
    pout = 16'd2000; unity_ratio = 1'b1; cyc(1);
    chk("R6 unity to panel again", int'(state), S_PNL);
    unity_ratio = 1'b0;
    pout = 16'd1937; cyc(2);
    chk("R9 reference is 2000", int'(state), S_PNL);
    pout = 16'd1874; cyc(1);
    chk("R8 downward drift exits", int'(state), S_TRK);
    pwr_code = 4'd0; unity_ratio = 1'b1; cyc(1);
    unity_ratio = 1'b0;
    pout = 16'd60000; cyc(3);
    chk("R8 zero code disables exit", int'(state), S_PNL);
  endtask

  task automatic t_force();
    pwr_code = 4'd4; pout = 16'd5000; cyc(1);
    chk("R8 drift to track before force", int'(state), S_TRK);
    pm_pin_n = 1'b0; cyc(1);
    chk("R10 pin forces panel", int'(state), S_PNL);
    pout = 16'd3000;
    ticks(CHK + 5); cyc(2);
    chk("R10 forced panel held", int'(state), S_PNL);
    pm_pin_n = 1'b1; cyc(2);
    chk("R9 reference resampled while forced", int'(state), S_PNL);
    ticks(CHK - 1); cyc(2);
    chk("R12 timer restarted while forced", int'(state), S_PNL);
    ticks(1); cyc(1);
    chk("R7 probe after release", int'(state), S_TRK);
    pm_sel = 1'b1; pm_reg = 1'b0; pm_pin_n = 1'b0; cyc(3);
    chk("R11 pin ignored under select", int'(state), S_TRK);
    pm_reg = 1'b1; cyc(1);
    chk("R11 register bit forces panel", int'(state), S_PNL);
    pm_sel = 1'b0; pm_reg = 1'b0;
    soft_done = 1'b0; set_cur(0, 0);
    do_reset();
    cyc(1);
    chk("R10 force from soft", int'(state), S_PNL);
    pm_pin_n = 1'b1; soft_done = 1'b1;
    do_reset();
    cyc(1);
    chk("R3 startup panel before force", int'(state), S_SPM);
    pm_pin_n = 1'b0; cyc(1);
    chk("R10 force from startup panel", int'(state), S_PNL);
    pm_pin_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; soft_done = 1'b0; unity_ratio = 1'b0;
    pm_pin_n = 1'b1; pm_sel = 1'b0; pm_reg = 1'b0;
    iin = '0; iout = '0; pout = 16'd1000; hold_code = 2'd0; pwr_code = 4'd4;
    th_in_hi = 10'd40; th_in_lo = 10'd24; th_out_hi = 10'd40; th_out_lo = 10'd24;
    cyc(3);
    t_soft_track();
    t_hyst();
    t_spm_hold(1, UNIT);
    t_spm_hold(2, 2 * UNIT);
    t_spm_hold(0, 0);
    t_unity();
    t_probe();
    t_power();
    t_force();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule